// File: doc/BRIEF.md
# Latching Interrupt Controller

This block gathers thirty-two external interrupt lines into one registered request for the processor core. It has two registers. The enable register decides which lines may reach the core. The pending register records which lines are asking for service. Software scans the pending register from bit 0 upward to find work, then acknowledges each line it has handled.

A build-time parameter picks one of three pending-register behaviours:

- **Level:** the pending register mirrors the synchronized inputs, and writes to it do nothing.
- **Edge:** rising edges are caught and held until software writes a 1 to the bit.
- **Legacy:** a high input is latched, and the bit is cleared by writing a 0 to it.

In both latching behaviours, a new set event takes precedence over a clear that lands on the same bit in the same cycle. This guarantees that no request is lost.

Access goes through a plain register port: a one-bit register select, a write enable, write data and combinational read data. Every input line passes through one register stage before any logic uses it. The request to the core is also registered.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, both the enable register and the pending register read as zero, and `cpuIrq` is 0.
- R2: With `regWe`=1 and `regSel`=0, the enable register loads `regWdata` at the clock edge. `regRdata` shows the enable register when `regSel`=0 and the pending register when `regSel`=1. Bit n of either register belongs to line n.
- R3: In edge mode, a 0-to-1 change of a synchronized input sets its pending bit. The bit stays set until a status write (`regWe`=1, `regSel`=1) carries a 1 in that position. Writing a 0 leaves the bit unchanged, and a steady high input does not set it again.
- R4: In level mode, the pending register equals the input value captured at the previous clock edge, and status writes have no effect on it.
- R5: In the latching modes, a line's pending bit is set whether or not the line is enabled.
- R6: In legacy mode, a synchronized input that is high sets its pending bit. A status write clears the bits where the data is 0 and leaves the bits where the data is 1 unchanged. A bit cleared while its input is still high is set again.
- R7: `cpuIrq` is the OR over all lines of (pending AND enable), taken one clock cycle earlier.
- R8: When a set event and a clearing status write hit the same pending bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | External interrupt lines |
| regSel | input | 1 | Register select: 0 = enable register, 1 = pending register |
| regWe | input | 1 | Write strobe for the selected register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the selected register |
| cpuIrq | output | 1 | Registered interrupt request to the core |

## Verification
The checker asserts the following relations on every cycle:

- The request equals the previous cycle's OR of pending AND enable.
- An enable write loads its data.
- In level mode, the pending register tracks the delayed input.
- In the latching modes, pending bits rise only where the synchronized input was high.
- Pending bits obey the clear polarity of their mode.
- In legacy mode, a high input always leaves its bit set.

Some behaviours can be shown only by the bench's scenarios, which drive all three modes side by side:

- The reset values.
- The exact cycle in which the request appears and disappears.
- That an edge-mode bit stays cleared while its input stays high.
- That a rising edge coinciding with a write-one acknowledge keeps the bit set.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

  // Pending-register behaviour chosen at build time
  typedef enum logic [1:0] {
    IRQ_MODE_LEVEL  = 2'd0,
    IRQ_MODE_EDGE   = 2'd1,
    IRQ_MODE_LEGACY = 2'd2
  } irq_mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic maskWr;
    logic statusWr;
    logic readStatus;
  } reg_strobe_t;

endpackage

// File: rtl/irq_ctl_ctrl.sv
module irq_ctl_ctrl
  import irq_ctl_pkg::*;
(
  input  logic        regSel,
  input  logic        regWe,
  output reg_strobe_t strobe
);

  always_comb begin
    strobe            = '0;
    strobe.readStatus = regSel;
    strobe.maskWr     = regWe && !regSel;
    strobe.statusWr   = regWe && regSel;
  end

endmodule

// File: rtl/irq_ctl_dpath.sv
module irq_ctl_dpath
  import irq_ctl_pkg::*;
#(
  parameter int        NUM_LINES = 32,
  parameter irq_mode_e MODE      = IRQ_MODE_EDGE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqIn,
  input  reg_strobe_t          strobe,
  input  logic [NUM_LINES-1:0] regWdata,
  output logic [NUM_LINES-1:0] regRdata,
  output logic                 cpuIrq,
  output logic [NUM_LINES-1:0] maskQ,
  output logic [NUM_LINES-1:0] statusQ,
  output logic [NUM_LINES-1:0] syncQ
);

  localparam logic [NUM_LINES-1:0] ZERO_VEC = '0;

  // Input capture stage
  always_ff @(posedge clk) begin
    if (!rst_n) syncQ <= ZERO_VEC;
    else        syncQ <= irqIn;
  end

  // Enable register
  always_ff @(posedge clk) begin
    if (!rst_n)             maskQ <= ZERO_VEC;
    else if (strobe.maskWr) maskQ <= regWdata;
  end

  // Pending register, one variant per mode
  generate
    if (MODE == IRQ_MODE_LEVEL) begin : g_level
      assign statusQ = syncQ;
    end else begin : g_latch
      logic [NUM_LINES-1:0] setVec;
      logic [NUM_LINES-1:0] clrVec;
      logic [NUM_LINES-1:0] statusR;

      if (MODE == IRQ_MODE_EDGE) begin : g_edge
        logic [NUM_LINES-1:0] prevQ;
        always_ff @(posedge clk) begin
          if (!rst_n) prevQ <= ZERO_VEC;
          else        prevQ <= syncQ;
        end
        assign setVec = syncQ & ~prevQ;
        assign clrVec = strobe.statusWr ? regWdata : ZERO_VEC;
      end else begin : g_legacy
        assign setVec = syncQ;
        assign clrVec = strobe.statusWr ? ~regWdata : ZERO_VEC;
      end

      // set dominates a simultaneous clear
      always_ff @(posedge clk) begin
        if (!rst_n) statusR <= ZERO_VEC;
        else        statusR <= (statusR & ~clrVec) | setVec;
      end
      assign statusQ = statusR;
    end
  endgenerate

  // Registered request to the core
  always_ff @(posedge clk) begin
    if (!rst_n) cpuIrq <= 1'b0;
    else        cpuIrq <= |(statusQ & maskQ);
  end

  assign regRdata = strobe.readStatus ? statusQ : maskQ;

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_ctl_pkg::*;
#(
  parameter int        NUM_LINES = 32,
  parameter irq_mode_e MODE      = IRQ_MODE_EDGE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 regSel,
  input  logic                 regWe,
  input  logic [NUM_LINES-1:0] regWdata,
  output logic [NUM_LINES-1:0] regRdata,
  output logic                 cpuIrq
);

  reg_strobe_t          strobe;
  logic [NUM_LINES-1:0] maskQ;
  logic [NUM_LINES-1:0] statusQ;
  logic [NUM_LINES-1:0] syncQ;

  irq_ctl_ctrl u_ctrl (
    .regSel (regSel),
    .regWe  (regWe),
    .strobe (strobe)
  );

  irq_ctl_dpath #(
    .NUM_LINES (NUM_LINES),
    .MODE      (MODE)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .irqIn    (irqIn),
    .strobe   (strobe),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .cpuIrq   (cpuIrq),
    .maskQ    (maskQ),
    .statusQ  (statusQ),
    .syncQ    (syncQ)
  );

endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk
  import irq_ctl_pkg::*;
#(
  parameter int        NUM_LINES = 32,
  parameter irq_mode_e MODE      = IRQ_MODE_EDGE
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irqIn,
  input logic                 regSel,
  input logic                 regWe,
  input logic [NUM_LINES-1:0] regWdata,
  input logic                 cpuIrq,
  input logic [NUM_LINES-1:0] maskQ,
  input logic [NUM_LINES-1:0] statusQ,
  input logic [NUM_LINES-1:0] syncQ
);

  localparam bit IS_LEVEL  = (MODE == IRQ_MODE_LEVEL);
  localparam bit IS_EDGE   = (MODE == IRQ_MODE_EDGE);
  localparam bit IS_LEGACY = (MODE == IRQ_MODE_LEGACY);

  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(regWe && !regSel)) |-> (maskQ == $past(regWdata)));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cpuIrq == |($past(statusQ & maskQ))));

  // R4
  level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_LEVEL && armed) |-> (statusQ == $past(irqIn)));

  // R3
  latch_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_LEVEL && armed) |-> ((statusQ & ~$past(statusQ) & ~$past(syncQ)) == '0));

  // R3
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_EDGE && armed && $past(regWe && regSel)) |->
      ((statusQ & $past(regWdata) & ~$past(syncQ)) == '0));

  // R6
  legacy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_LEGACY && armed && $past(regWe && regSel)) |->
      ((statusQ & ~$past(regWdata) & ~$past(syncQ)) == '0));

  // R8
  legacy_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_LEGACY && armed) |-> (($past(syncQ) & ~statusQ) == '0));

endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .MODE      (MODE)
) chkInst (
  .clk      (clk),
  .rst_n    (rst_n),
  .irqIn    (irqIn),
  .regSel   (regSel),
  .regWe    (regWe),
  .regWdata (regWdata),
  .cpuIrq   (cpuIrq),
  .maskQ    (maskQ),
  .statusQ  (statusQ),
  .syncQ    (syncQ)
);

// File: tb/tb_irq_latch_ctrl.sv
`timescale 1ns/1ps
module tb_irq_latch_ctrl;
  import irq_ctl_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irqIn;
  logic        regSel;
  logic        regWe;
  logic [31:0] regWdata;
  logic [31:0] rdL, rdE, rdG;
  logic        irqL, irqE, irqG;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_latch_ctrl #(.NUM_LINES(32), .MODE(IRQ_MODE_EDGE)) dut (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .regRdata(rdE), .cpuIrq(irqE));

  irq_latch_ctrl #(.NUM_LINES(32), .MODE(IRQ_MODE_LEVEL)) dutLevel (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .regRdata(rdL), .cpuIrq(irqL));

  irq_latch_ctrl #(.NUM_LINES(32), .MODE(IRQ_MODE_LEGACY)) dutLegacy (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .regRdata(rdG), .cpuIrq(irqG));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic sel, input logic [31:0] data);
    regSel = sel; regWe = 1'b1; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic selReg(input logic sel);
    regSel = sel;
    #1;
  endtask

  task automatic clearAll();
    irqIn = '0;
    tick(3);
    wrReg(1'b1, 32'hFFFF_FFFF);
    wrReg(1'b1, 32'h0000_0000);
    tick(2);
  endtask

  task automatic testReset();
    selReg(1'b0);
    check("R1 mask edge", rdE, '0);
    check("R1 mask level", rdL, '0);
    check("R1 mask legacy", rdG, '0);
    selReg(1'b1);
    check("R1 status edge", rdE, '0);
    check("R1 status legacy", rdG, '0);
    check("R1 irq", {29'd0, irqL, irqE, irqG}, '0);
  endtask

  task automatic testMask();
    wrReg(1'b0, 32'hA5A5_0F0F);
    selReg(1'b0);
    check("R2 mask readback edge", rdE, 32'hA5A5_0F0F);
    check("R2 mask readback legacy", rdG, 32'hA5A5_0F0F);
    wrReg(1'b0, 32'h0);
    selReg(1'b0);
    check("R2 mask cleared", rdL, 32'h0);
  endtask

  task automatic testLevel();
    irqIn = 32'h0000_0011;
    tick(3);
    selReg(1'b1);
    check("R4 level status", rdL, 32'h11);
    check("R5 edge latched while masked", rdE, 32'h11);
    check("R6 legacy latched", rdG, 32'h11);
    check("R7 masked no irq", {29'd0, irqL, irqE, irqG}, '0);
    wrReg(1'b0, 32'h1);
    tick(1);
    check("R7 enabled irq", {29'd0, irqL, irqE, irqG}, 32'h7);
    wrReg(1'b1, 32'hFFFF_FFFF);
    selReg(1'b1);
    check("R4 level ignores write", rdL, 32'h11);
    check("R3 edge one clears, steady high no reset", rdE, 32'h0);
    check("R6 legacy one no effect", rdG, 32'h11);
    irqIn = '0;
    tick(3);
    selReg(1'b1);
    check("R4 level follows low", rdL, 32'h0);
    check("R6 legacy holds after input low", rdG, 32'h11);
    wrReg(1'b1, 32'hFFFF_FFEF);
    selReg(1'b1);
    check("R6 legacy zero clears bit4", rdG, 32'h01);
    wrReg(1'b1, 32'hFFFF_FFFE);
    tick(2);
    selReg(1'b1);
    check("R6 legacy zero clears bit0", rdG, 32'h0);
    check("R7 irq drops", {29'd0, irqL, irqE, irqG}, '0);
  endtask

  task automatic testEdge();
    irqIn = 32'h8;
    tick(1);
    irqIn = '0;
    tick(3);
    selReg(1'b1);
    check("R3 edge pulse latched", rdE, 32'h8);
    check("R4 level pulse gone", rdL, 32'h0);
    check("R5 masked line no irq", {31'd0, irqE}, 32'h0);
    wrReg(1'b1, 32'h0);
    selReg(1'b1);
    check("R3 edge zero no effect", rdE, 32'h8);
    check("R6 legacy zero clears", rdG, 32'h0);
    wrReg(1'b1, 32'h8);
    selReg(1'b1);
    check("R3 edge one clears", rdE, 32'h0);
  endtask

  task automatic testLegacyHeld();
    irqIn = 32'h4;
    tick(3);
    wrReg(1'b1, 32'h0);
    selReg(1'b1);
    check("R6 legacy relatch while high", rdG, 32'h4);
    check("R3 edge zero no effect held", rdE, 32'h4);
    clearAll();
    selReg(1'b1);
    check("R6 legacy cleared when low", rdG, 32'h0);
  endtask

  task automatic testCollision();
    irqIn = 32'h2;
    tick(1);
    wrReg(1'b1, 32'h2);
    selReg(1'b1);
    check("R8 edge set wins over clear", rdE, 32'h2);
    wrReg(1'b1, 32'h2);
    selReg(1'b1);
    check("R3 edge later clear works", rdE, 32'h0);
    clearAll();
  endtask

  task automatic testTiming();
    wrReg(1'b0, 32'h1);
    tick(1);
    irqIn = 32'h1;
    tick(1);
    check("R7 level irq not yet", {31'd0, irqL}, 32'h0);
    tick(1);
    selReg(1'b1);
    check("R7 level irq one cycle after status", {31'd0, irqL}, 32'h1);
    check("R7 edge status set", rdE, 32'h1);
    check("R7 edge irq registered lag", {31'd0, irqE}, 32'h0);
    tick(1);
    check("R7 latched irq", {30'd0, irqE, irqG}, 32'h3);
    wrReg(1'b0, 32'h0);
    check("R7 irq holds one cycle after mask", {31'd0, irqE}, 32'h1);
    tick(1);
    check("R7 irq drops after mask", {29'd0, irqL, irqE, irqG}, 32'h0);
    clearAll();
  endtask

  initial begin
    rst_n = 1'b0; irqIn = '0; regSel = 1'b0; regWe = 1'b0; regWdata = '0;
    tick(4);
    rst_n = 1'b1;
    tick(1);
    testReset();
    testMask();
    testLevel();
    testEdge();
    clearAll();
    testLegacyHeld();
    testCollision();
    testTiming();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

endmodule